// File: doc/BRIEF.md
# Multichannel Input Edge Conditioner

This block takes a wide bus of asynchronous digital inputs and turns it into clean, clock-aligned edge events for a downstream timestamp capture stage. Each channel is first passed through a multi-flop synchronizer. An optional per-channel polarity flip is then applied. Finally, the conditioned level feeds two independent detectors: one for rising transitions and one for falling transitions, each with its own per-channel enable. The result is two hit vectors in which every set bit is a single-cycle pulse.

The same conditioned levels also drive a trigger path. A per-channel mask chooses which channels may act as a trigger source, and their OR is gated by an arm-then-fire sequence. After software arms the block, the first cycle in which any selected channel is high produces one trigger pulse and disarms the block. An explicit fire command issued while armed forces the pulse at once.

All configuration is written as 32-bit words, one word per 32-channel slice. Only the lower channels are populated. Channels above the populated count are tied low.

Top module: `edgecond_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `lead_hit`, `trail_hit`, `sync_pulse` and `sync_armed` are all zero. Reset also clears every configuration word, which leaves no inversion, all edge enables off and an empty trigger mask.
- R2: With SYNC_STAGES=2, an input transition applied before rising edge k appears on the hit outputs after edge k+2, and the hit lasts exactly one cycle.
- R3: `lead_hit[i]` pulses when the conditioned level of channel i goes from 0 to 1, and only while its leading-edge enable bit is set.
- R4: `trail_hit[i]` pulses when the conditioned level of channel i goes from 1 to 0, and only while its trailing-edge enable bit, which is separate from the leading-edge enable, is set.
- R5: The conditioned level of channel i is its synchronized input XOR its inversion bit. On an inverted channel, a raw rise therefore appears as a trailing edge and a raw fall as a leading edge.
- R6: A configuration write happens at the rising edge where `cfg_wr` is high. `cfg_addr` is {field[1:0], word}, with field 0 = inversion, 1 = leading-edge enable, 2 = trailing-edge enable and 3 = trigger mask. Word 0 covers channels 31..0 and word 1 covers channels 63..32, with data bit b mapping to channel 32*word+b. When `cfg_wr` is low, the configuration does not change.
- R7: Changing an inversion bit while the input is steady never produces a hit on that channel.
- R8: Channels at or above USED_CH (53 by default) never produce hits and never act as a trigger source, whatever their input, inversion, enable or mask bits are.
- R9: `sync_arm` sets `sync_armed` at the next edge. While armed, the first cycle in which any masked conditioned input is high yields a single one-cycle `sync_pulse` and clears `sync_armed` at the same edge. Through the synchronizer, this pulse is visible after the third edge following the input change.
- R10: `sync_fire` while armed produces `sync_pulse` at the next edge and disarms the block. `sync_fire`, or a high masked input, has no effect while the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | NUM_CH | Asynchronous channel inputs |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_ADDR_W | {field, word} configuration address |
| cfg_wdata | input | WORD_W | Configuration write data |
| sync_arm | input | 1 | Arm the trigger |
| sync_fire | input | 1 | Force the trigger when armed |
| lead_hit | output | NUM_CH | One-cycle leading-edge hits |
| trail_hit | output | NUM_CH | One-cycle trailing-edge hits |
| sync_pulse | output | 1 | One-cycle trigger pulse |
| sync_armed | output | 1 | Trigger armed state |

## Verification
The bench builds the block with its defaults: 64 channels in two configuration words, 53 populated channels and a two-flop synchronizer. With these values, both configuration words are exercised. The eleven tied-off channels 53..63 can also be driven, inverted, enabled and masked, so the claim that they stay silent is checked at the ports. The fixed three-edge latency gives the stimulus table exact sampling points. Mixed inversion on channels 4..7 shows the swap of edge types, and the leading and trailing enables are set to different patterns.

// File: rtl/edgecond_pkg.sv
package edgecond_pkg;

  // configuration field selector, upper bits of the config address
  typedef enum logic [1:0] {
    FLD_INV   = 2'd0,
    FLD_LEAD  = 2'd1,
    FLD_TRAIL = 2'd2,
    FLD_MASK  = 2'd3
  } cfg_field_e;

  localparam int unsigned NUM_FIELDS = 4;

  // width of the word index inside the config address
  function automatic int unsigned widx_bits(input int unsigned words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction

endpackage

// File: rtl/edgecond_sync.sv
module edgecond_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= '0;
        else     stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= '0;
        else     stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/edgecond_cfg.sv
module edgecond_cfg
  import edgecond_pkg::*;
#(
  parameter int unsigned NUM_CH  = 64,
  parameter int unsigned USED_CH = 53,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned NUM_WORDS = (NUM_CH + WORD_W - 1) / WORD_W,
  localparam int unsigned WIDX_W    = widx_bits(NUM_WORDS),
  localparam int unsigned ADDR_W    = 2 + WIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [NUM_CH-1:0] inv_o,
  output logic [NUM_CH-1:0] lead_en_o,
  output logic [NUM_CH-1:0] trail_en_o,
  output logic [NUM_CH-1:0] mask_o
);

  localparam int unsigned PAD_W = NUM_WORDS * WORD_W;
  localparam logic [PAD_W-1:0] ONE = PAD_W'(1);
  // bits of populated channels; unpopulated ones can never be stored
  localparam logic [PAD_W-1:0] USED_FLAT = (ONE << USED_CH) - ONE;

  logic [WORD_W-1:0] regs_q [NUM_FIELDS][NUM_WORDS];
  logic [PAD_W-1:0]  flat   [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'((f << WIDX_W) + w);
      localparam logic [WORD_W-1:0] KEEP    = USED_FLAT[w*WORD_W +: WORD_W];
      always_ff @(posedge clk) begin
        if (rst)
          regs_q[f][w] <= '0;
        else if (cfg_wr && (cfg_addr == MY_ADDR))
          regs_q[f][w] <= cfg_wdata & KEEP;
      end
      assign flat[f][w*WORD_W +: WORD_W] = regs_q[f][w];
    end
  end

  assign inv_o      = flat[FLD_INV][NUM_CH-1:0];
  assign lead_en_o  = flat[FLD_LEAD][NUM_CH-1:0];
  assign trail_en_o = flat[FLD_TRAIL][NUM_CH-1:0];
  assign mask_o     = flat[FLD_MASK][NUM_CH-1:0];

  // R6: configuration only moves on a write strobe
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable({inv_o, lead_en_o, trail_en_o, mask_o}));

endmodule

// File: rtl/edgecond_edge.sv
module edgecond_edge #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sync_i,
  input  logic [NUM_CH-1:0] inv_i,
  input  logic [NUM_CH-1:0] lead_en_i,
  input  logic [NUM_CH-1:0] trail_en_i,
  output logic [NUM_CH-1:0] cond_o,
  output logic [NUM_CH-1:0] lead_o,
  output logic [NUM_CH-1:0] trail_o
);

  logic [NUM_CH-1:0] prev_q;
  logic [NUM_CH-1:0] prev_cond;

  // both sides of the comparison use the present inversion setting, so a
  // polarity change alone cannot look like a transition
  assign cond_o    = sync_i ^ inv_i;
  assign prev_cond = prev_q ^ inv_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      lead_o  <= '0;
      trail_o <= '0;
    end else begin
      prev_q  <= sync_i;
      lead_o  <= lead_en_i  &  cond_o & ~prev_cond;
      trail_o <= trail_en_i & ~cond_o &  prev_cond;
    end
  end

  // R3: a leading hit needs its enable in the cycle it was formed
  p_lead_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    (lead_o & ~$past(lead_en_i)) == '0);
  // R4: same for the trailing side
  p_trail_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    (trail_o & ~$past(trail_en_i)) == '0);
  // R2: every hit is a single-cycle pulse
  p_hit_single_r2: assert property (@(posedge clk) disable iff (rst)
    ((lead_o & $past(lead_o)) | (trail_o & $past(trail_o))) == '0);
  // R4: the two detectors never fire together on one channel
  p_no_both_r4: assert property (@(posedge clk) disable iff (rst)
    (lead_o & trail_o) == '0);
  // R7: with a steady synchronized input no hit can appear
  p_steady_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(sync_i) == $past(prev_q)) |-> ((lead_o | trail_o) == '0));

endmodule

// File: rtl/edgecond_trig.sv
module edgecond_trig #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cond_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              arm_i,
  input  logic              fire_i,
  output logic              pulse_o,
  output logic              armed_o
);

  logic any_hit;

  assign any_hit = |(cond_i & mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (armed_o && (any_hit || fire_i)) begin
        pulse_o <= 1'b1;
        armed_o <= 1'b0;
      end else if (arm_i) begin
        armed_o <= 1'b1;
      end
    end
  end

  // R9: a pulse only follows an armed cycle
  p_pulse_needs_arm_r9: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(armed_o));
  // R9: the pulse and the disarm coincide
  p_pulse_disarms_r9: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> !armed_o);
  // R9: one cycle wide
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R10: fire while disarmed does nothing
  p_fire_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && fire_i) |=> !pulse_o);

endmodule

// File: rtl/edgecond_top.sv
module edgecond_top
  import edgecond_pkg::*;
#(
  parameter int unsigned NUM_CH      = 64,
  parameter int unsigned USED_CH     = 53,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CFG_ADDR_W =
    2 + widx_bits((NUM_CH + WORD_W - 1) / WORD_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     raw_in,
  input  logic                  cfg_wr,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0]     cfg_wdata,
  input  logic                  sync_arm,
  input  logic                  sync_fire,
  output logic [NUM_CH-1:0]     lead_hit,
  output logic [NUM_CH-1:0]     trail_hit,
  output logic                  sync_pulse,
  output logic                  sync_armed
);

  localparam logic [NUM_CH-1:0] ONE       = NUM_CH'(1);
  localparam logic [NUM_CH-1:0] USED_MASK = (ONE << USED_CH) - ONE;

  logic [NUM_CH-1:0] raw_used;
  logic [NUM_CH-1:0] sync_lvl;
  logic [NUM_CH-1:0] cond_lvl;
  logic [NUM_CH-1:0] inv_cfg, lead_cfg, trail_cfg, mask_cfg;

  // unpopulated channels are tied low before the synchronizer
  assign raw_used = raw_in & USED_MASK;

  edgecond_cfg #(
    .NUM_CH (NUM_CH),
    .USED_CH(USED_CH),
    .WORD_W (WORD_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .inv_o     (inv_cfg),
    .lead_en_o (lead_cfg),
    .trail_en_o(trail_cfg),
    .mask_o    (mask_cfg)
  );

  edgecond_sync #(
    .WIDTH (NUM_CH),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(raw_used),
    .q_o(sync_lvl)
  );

  edgecond_edge #(
    .NUM_CH(NUM_CH)
  ) u_edge (
    .clk       (clk),
    .rst       (rst),
    .sync_i    (sync_lvl),
    .inv_i     (inv_cfg),
    .lead_en_i (lead_cfg),
    .trail_en_i(trail_cfg),
    .cond_o    (cond_lvl),
    .lead_o    (lead_hit),
    .trail_o   (trail_hit)
  );

  edgecond_trig #(
    .NUM_CH(NUM_CH)
  ) u_trig (
    .clk    (clk),
    .rst    (rst),
    .cond_i (cond_lvl),
    .mask_i (mask_cfg),
    .arm_i  (sync_arm),
    .fire_i (sync_fire),
    .pulse_o(sync_pulse),
    .armed_o(sync_armed)
  );

  // R8: nothing ever appears on unpopulated channels
  p_unused_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ((lead_hit | trail_hit) & ~USED_MASK) == '0);
  // R1: outputs idle in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (lead_hit == '0 && trail_hit == '0 && !sync_pulse && !sync_armed));

endmodule

// File: tb/edgecond_top_bench.sv
`timescale 1ns/1ps
module edgecond_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] raw_in = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sync_arm = 1'b0;
  logic        sync_fire = 1'b0;
  logic [63:0] lead_hit, trail_hit;
  logic        sync_pulse, sync_armed;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  edgecond_top u_edgecond_top (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw_in),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sync_arm  (sync_arm),
    .sync_fire (sync_fire),
    .lead_hit  (lead_hit),
    .trail_hit (trail_hit),
    .sync_pulse(sync_pulse),
    .sync_armed(sync_armed)
  );

  // {raw, expected lead, expected trail}; inversion on ch4..7,
  // lead enables ch0-3,8-11,40,60; trail enables ch0-7,40,60
  localparam logic [191:0] VEC [8] = '{
    {64'h0000_0000_0000_00FF, 64'h0000_0000_0000_000F, 64'h0000_0000_0000_00F0},
    {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_000F},
    {64'h0000_0000_0000_0F00, 64'h0000_0000_0000_0F00, 64'h0000_0000_0000_0000},
    {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0100_0000_0F0F, 64'h0000_0000_0000_00F0},
    {64'h0000_0100_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_000F},
    {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0100_0000_0000},
    {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 hits in reset", lead_hit | trail_hit, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 hits after reset", lead_hit | trail_hit, 64'h0);
    chk("R1 trigger after reset", {62'h0, sync_pulse, sync_armed}, 64'h0);

    // R6 configuration through both words of each field
    wr(3'd2, 32'h0000_0F0F);
    wr(3'd3, 32'h1000_0100);
    wr(3'd4, 32'h0000_00FF);
    wr(3'd5, 32'h1000_0100);
    wr(3'd1, 32'h1000_0000);
    wr(3'd0, 32'h0000_00F0);
    // R7 inverting ch4..7 with steady input gives no hits
    for (int c = 0; c < 4; c++) begin
      chk("R7 no hit after inversion write", lead_hit | trail_hit, 64'h0);
      @(negedge clk);
    end

    // R2 R3 R4 R5 R6 R8 table walk
    for (int i = 0; i < 8; i++) begin
      raw_in = VEC[i][191:128];
      repeat (3) @(negedge clk);
      chk("R3 lead hit", lead_hit, VEC[i][127:64]);
      chk("R4 trail hit", trail_hit, VEC[i][63:0]);
      @(negedge clk);
      chk("R2 one-cycle hit", lead_hit | trail_hit, 64'h0);
    end

    // R7 flip inversion on enabled ch0 while its input is steady high
    wr(3'd0, 32'h0000_00F1);
    for (int c = 0; c < 4; c++) begin
      chk("R7 no hit on polarity change", lead_hit | trail_hit, 64'h0);
      @(negedge clk);
    end
    wr(3'd0, 32'h0000_00F0);
    raw_in = '0;
    repeat (5) @(negedge clk);

    // trigger: mask ch20 only
    wr(3'd6, 32'h0010_0000);
    wr(3'd7, 32'h0000_0000);
    sync_fire = 1'b1;
    @(negedge clk);
    sync_fire = 1'b0;
    chk("R10 fire while disarmed", {62'h0, sync_pulse, sync_armed}, 64'h0);
    sync_arm = 1'b1;
    @(negedge clk);
    sync_arm = 1'b0;
    chk("R9 armed", {62'h0, sync_pulse, sync_armed}, 64'h1);
    raw_in[20] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 no pulse before latency", {63'h0, sync_pulse}, 64'h0);
    @(negedge clk);
    chk("R9 pulse and disarm", {62'h0, sync_pulse, sync_armed}, 64'h2);
    @(negedge clk);
    chk("R9 single pulse", {63'h0, sync_pulse}, 64'h0);
    repeat (2) @(negedge clk);
    chk("R10 masked high while disarmed", {62'h0, sync_pulse, sync_armed}, 64'h0);
    sync_arm = 1'b1;
    @(negedge clk);
    sync_arm = 1'b0;
    chk("R9 armed with input high", {62'h0, sync_pulse, sync_armed}, 64'h1);
    @(negedge clk);
    chk("R9 immediate pulse", {62'h0, sync_pulse, sync_armed}, 64'h2);
    raw_in = '0;
    repeat (4) @(negedge clk);

    sync_arm = 1'b1;
    @(negedge clk);
    sync_arm = 1'b0; sync_fire = 1'b1;
    @(negedge clk);
    sync_fire = 1'b0;
    chk("R10 fire while armed", {62'h0, sync_pulse, sync_armed}, 64'h2);

    // R8 ch60 inverted, masked and driven: must not trigger
    wr(3'd6, 32'h0);
    wr(3'd7, 32'h1000_0000);
    raw_in[60] = 1'b1;
    sync_arm = 1'b1;
    @(negedge clk);
    sync_arm = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 unused channel not a trigger", {62'h0, sync_pulse, sync_armed}, 64'h1);
    sync_fire = 1'b1;
    @(negedge clk);
    sync_fire = 1'b0;
    chk("R10 fire clears arm", {62'h0, sync_pulse, sync_armed}, 64'h2);

    // R1 reset clears arm state and configuration
    sync_arm = 1'b1;
    @(negedge clk);
    sync_arm = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears arm", {62'h0, sync_pulse, sync_armed}, 64'h0);
    raw_in = 64'h1;
    repeat (3) @(negedge clk);
    chk("R1 enables cleared by reset", lead_hit | trail_hit, 64'h0);

    summary();
  end

endmodule